// File: doc/BRIEF.md
# Two-Level Sample Accumulation Sequencer

This block sums signed per-sample values for several channels over an accumulation interval built from two nested counts. An inner stage adds a programmable number of consecutive samples into a group result. An outer stage adds a programmable number of those group results. When the last sample of the last group arrives, the completed sums are copied into hold registers, a sticky interrupt flag is raised for the processor, and both stages restart empty, so the next interval begins with the very next sample.

The group length is selected by a 2-bit code and the number of groups by a plain count. A new setting on either input takes effect only at an interval boundary, so an interval in progress always completes with the lengths it started with. Each stage saturates at the signed 32-bit limits rather than wrapping. Producing the samples and scaling the sums into energy units are handled elsewhere.

Top module: `acc2_interval`

## Requirements
- R1: The group length is `BASE_PRE << grp_sel`, where `grp_sel` is a 2-bit code. With the default `BASE_PRE` of 42, codes 0, 1, 2 and 3 give 42, 84, 168 and 336 samples.
- R2: One interval spans (group length) × G samples, where G is `grp_cnt`. A `grp_cnt` of 0 is treated as 1.
- R3: Each channel's interval sum is the signed sum of that channel's samples in the interval. Channels are independent. Channel c occupies bits [c*W_IN +: W_IN] of `smp_data` and bits [c*32 +: 32] of `xfer_sum`.
- R4: Neither stage wraps. A group result clamps to 2147483647 or -2147483648, and so does the interval sum.
- R5: `xfer_sum` takes the new interval sums on the clock edge that accepts the final sample of the interval. At all other times it holds its value.
- R6: Both stages restart at the interval boundary. The next interval's sum contains exactly that interval's samples.
- R7: `xfer_irq` is set by the interval-end edge and stays set until `irq_clr` is high on an edge with no interval end. When interval end and `irq_clr` occur on the same edge, the flag stays set.
- R8: A change of `grp_sel` or `grp_cnt` during an interval does not change that interval's length. The new setting is captured on the interval-end edge.
- R9: A cycle with `smp_vld` low adds nothing and advances no count, whatever `smp_data` holds.
- R10: Synchronous reset clears all sums and the flag, and loads the current `grp_sel` and `grp_cnt` as the first interval's setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | N_CH*W_IN | Signed samples, one field per channel |
| grp_sel | input | 2 | Group-length code |
| grp_cnt | input | W_CYC | Groups per interval |
| irq_clr | input | 1 | Clears the interval-end flag |
| xfer_sum | output | N_CH*32 | Latched signed interval sums |
| xfer_irq | output | 1 | Sticky interval-end flag |

## Verification
The stimulus uses constant samples of mixed sign on two channels. Each vector gives an expected sum of value × length, so a single miscounted sample, a swapped channel or a sign error shows up as a distinct wrong total. Small values across all four group codes and several group counts, including zero, test R1 and R2. Full-scale values test saturation. One full-scale vector stays just under the limit, one clamps only in the outer stage, and one clamps already in a single group. Between strobes the bench drives garbage on `smp_data`. Directed tests change the configuration in the middle of an interval, and they clear the flag on the same edge that ends an interval.

// File: rtl/acc2_pkg.sv
package acc2_pkg;
  localparam int W_ACC = 32;
  typedef logic signed [W_ACC-1:0] acc_t;
  localparam acc_t ACC_MAX = {1'b0, {(W_ACC-1){1'b1}}};
  localparam acc_t ACC_MIN = {1'b1, {(W_ACC-1){1'b0}}};

  // add with clamping at the signed limits
  function automatic acc_t sat_add(input acc_t a, input acc_t b);
    logic signed [W_ACC:0] s;
    s = {a[W_ACC-1], a} + {b[W_ACC-1], b};
    if (s[W_ACC] != s[W_ACC-1]) return s[W_ACC] ? ACC_MIN : ACC_MAX;
    return s[W_ACC-1:0];
  endfunction
endpackage

// File: rtl/acc2_seq.sv
module acc2_seq #(
  parameter int BASE_PRE = 42,
  parameter int W_CYC    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_vld,
  input  logic [1:0]       grp_sel,
  input  logic [W_CYC-1:0] grp_cnt,
  output logic             grp_end,
  output logic             ivl_end,
  output logic [1:0]       act_sel,
  output logic [W_CYC-1:0] act_cnt
);
  localparam int MAX_PRE = BASE_PRE * 8;
  localparam int W_PRE   = $clog2(MAX_PRE + 1);

  logic [W_PRE-1:0] pre_idx, pre_len;
  logic [W_CYC-1:0] grp_idx, grp_last;

  always_comb begin
    pre_len  = W_PRE'(BASE_PRE) << act_sel;
    grp_last = (act_cnt == '0) ? '0 : act_cnt - W_CYC'(1);
    grp_end  = smp_vld && (pre_idx == pre_len - W_PRE'(1));
    ivl_end  = grp_end && (grp_idx == grp_last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_idx <= '0;
      grp_idx <= '0;
      act_sel <= grp_sel;
      act_cnt <= grp_cnt;
    end else if (smp_vld) begin
      pre_idx <= grp_end ? '0 : pre_idx + W_PRE'(1);
      if (ivl_end) begin
        grp_idx <= '0;
        act_sel <= grp_sel;
        act_cnt <= grp_cnt;
      end else if (grp_end) begin
        grp_idx <= grp_idx + W_CYC'(1);
      end
    end
  end
endmodule

// File: rtl/acc2_lane.sv
module acc2_lane
  import acc2_pkg::*;
#(
  parameter int W_IN = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            smp_vld,
  input  logic [W_IN-1:0] smp,
  input  logic            grp_end,
  input  logic            ivl_end,
  output acc_t            xfer
);
  acc_t acc1, acc2, s_ext, l1, l2;

  always_comb begin
    s_ext = {{(W_ACC-W_IN){smp[W_IN-1]}}, smp};
    l1    = sat_add(acc1, s_ext);
    l2    = sat_add(acc2, l1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc1 <= '0;
      acc2 <= '0;
      xfer <= '0;
    end else if (smp_vld) begin
      if (grp_end) begin
        acc1 <= '0;
        if (ivl_end) begin
          acc2 <= '0;
          xfer <= l2;
        end else begin
          acc2 <= l2;
        end
      end else begin
        acc1 <= l1;
      end
    end
  end
endmodule

// File: rtl/acc2_interval.sv
module acc2_interval #(
  parameter int N_CH     = 2,
  parameter int W_IN     = 24,
  parameter int BASE_PRE = 42,
  parameter int W_CYC    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               smp_vld,
  input  logic [N_CH*W_IN-1:0] smp_data,
  input  logic [1:0]         grp_sel,
  input  logic [W_CYC-1:0]   grp_cnt,
  input  logic               irq_clr,
  output logic [N_CH*32-1:0] xfer_sum,
  output logic               xfer_irq
);
  logic             grp_end, ivl_end;
  logic [1:0]       act_sel;
  logic [W_CYC-1:0] act_cnt;

  acc2_seq #(.BASE_PRE(BASE_PRE), .W_CYC(W_CYC)) u_seq (
    .clk(clk), .rst(rst), .smp_vld(smp_vld),
    .grp_sel(grp_sel), .grp_cnt(grp_cnt),
    .grp_end(grp_end), .ivl_end(ivl_end),
    .act_sel(act_sel), .act_cnt(act_cnt)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_lane
    acc2_lane #(.W_IN(W_IN)) u_lane (
      .clk(clk), .rst(rst), .smp_vld(smp_vld),
      .smp(smp_data[c*W_IN +: W_IN]),
      .grp_end(grp_end), .ivl_end(ivl_end),
      .xfer(xfer_sum[c*32 +: 32])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)          xfer_irq <= 1'b0;
    else if (ivl_end) xfer_irq <= 1'b1;
    else if (irq_clr) xfer_irq <= 1'b0;
  end
endmodule

// File: rtl/acc2_interval_chk.sv
module acc2_interval_chk #(
  parameter int W_SUM = 64,
  parameter int W_CYC = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             smp_vld,
  input logic             irq_clr,
  input logic             xfer_irq,
  input logic [W_SUM-1:0] xfer_sum,
  input logic             ivl_end,
  input logic [1:0]       act_sel,
  input logic [W_CYC-1:0] act_cnt
);
  a_r7_irq_set: assert property (@(posedge clk) disable iff (rst)
    ivl_end |=> xfer_irq);
  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (xfer_irq && !irq_clr) |=> xfer_irq);
  a_r7_irq_clear: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && !ivl_end) |=> !xfer_irq);
  a_r5_hold_sums: assert property (@(posedge clk) disable iff (rst)
    !ivl_end |=> $stable(xfer_sum));
  a_r8_cfg_steady: assert property (@(posedge clk) disable iff (rst)
    !ivl_end |=> ($stable(act_sel) && $stable(act_cnt)));
  a_r9_end_on_strobe: assert property (@(posedge clk) disable iff (rst)
    ivl_end |-> smp_vld);
endmodule

bind acc2_interval acc2_interval_chk #(.W_SUM(N_CH*32), .W_CYC(W_CYC)) u_chk (
  .clk(clk), .rst(rst), .smp_vld(smp_vld), .irq_clr(irq_clr),
  .xfer_irq(xfer_irq), .xfer_sum(xfer_sum), .ivl_end(ivl_end),
  .act_sel(act_sel), .act_cnt(act_cnt)
);

// File: tb/test_acc2_interval.sv
module test_acc2_interval;
  localparam int NV = 7;

  typedef struct packed {
    logic [1:0]         sel;
    logic [7:0]         cnt;
    logic signed [23:0] s0;
    logic signed [23:0] s1;
    logic signed [31:0] e0;
    logic signed [31:0] e1;
  } vec_t;

  // R1 R2 R3 R4 R6: value x (42<<sel) x max(cnt,1), clamped
  localparam vec_t VEC [NV] = '{
    '{2'd0, 8'd1,  24'sd100,     -24'sd7,      32'sd4200,       -32'sd294},
    '{2'd0, 8'd50, 24'sd1000,    -24'sd1000,   32'sd2100000,    -32'sd2100000},
    '{2'd1, 8'd3,  24'sd8388607, -24'sd8388608, 32'sd2113928964, -32'sd2113929216},
    '{2'd0, 8'd7,  24'sd8388607, -24'sd8388608, 32'sd2147483647, -32'sd2147483648},
    '{2'd3, 8'd1,  24'sd8388607, -24'sd8388608, 32'sd2147483647, -32'sd2147483648},
    '{2'd2, 8'd0,  24'sd5,       -24'sd3,      32'sd840,        -32'sd504},
    '{2'd2, 8'd2,  -24'sd1,      24'sd1,       -32'sd336,       32'sd336}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_vld = 1'b0;
  logic [47:0] smp_data = '0;
  logic [1:0]  grp_sel = 2'd0;
  logic [7:0]  grp_cnt = 8'd0;
  logic        irq_clr = 1'b0;
  logic [63:0] xfer_sum;
  logic        xfer_irq;
  int nvec = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  acc2_interval i_acc2_interval (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_data(smp_data),
    .grp_sel(grp_sel), .grp_cnt(grp_cnt), .irq_clr(irq_clr),
    .xfer_sum(xfer_sum), .xfer_irq(xfer_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, $signed(act), $signed(exp));
    end
  endtask

  // one strobe, then one idle cycle carrying junk data (R9)
  task automatic put(input logic [23:0] a, input logic [23:0] b, input logic clr);
    @(negedge clk);
    smp_vld  = 1'b1;
    smp_data = {b, a};
    irq_clr  = clr;
    @(negedge clk);
    smp_vld  = 1'b0;
    irq_clr  = 1'b0;
    smp_data = {24'h5A5A5, 24'h7F3C1};
  endtask

  task automatic clear_irq();
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    grp_sel = VEC[0].sel;
    grp_cnt = VEC[0].cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 sum0 after reset", xfer_sum[31:0], 32'd0);
    chk("R10 sum1 after reset", xfer_sum[63:32], 32'd0);
    chk("R10 irq after reset", {31'd0, xfer_irq}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      int n;
      n = (42 << VEC[i].sel) * ((VEC[i].cnt == 0) ? 1 : int'(VEC[i].cnt));
      for (int k = 0; k < n; k++) begin
        if (k == n - 1) begin
          grp_sel = (i < NV - 1) ? VEC[i+1].sel : 2'd0;
          grp_cnt = (i < NV - 1) ? VEC[i+1].cnt : 8'd1;
        end
        put(VEC[i].s0, VEC[i].s1, 1'b0);
        if (k == n - 2) chk("R2 no irq before last sample", {31'd0, xfer_irq}, 32'd0);
      end
      chk("R3 R4 R6 ch0 sum", xfer_sum[31:0], VEC[i].e0);
      chk("R3 R4 R6 ch1 sum", xfer_sum[63:32], VEC[i].e1);
      chk("R7 irq at interval end", {31'd0, xfer_irq}, 32'd1);
      clear_irq();
      chk("R7 irq cleared", {31'd0, xfer_irq}, 32'd0);
      chk("R5 ch0 held", xfer_sum[31:0], VEC[i].e0);
    end

    // R8: setting changed mid-interval; active interval stays 42 samples
    for (int k = 0; k < 10; k++) put(24'sd1, 24'sd1, 1'b0);
    grp_sel = 2'd1;
    grp_cnt = 8'd1;
    for (int k = 0; k < 31; k++) put(24'sd1, 24'sd1, 1'b0);
    chk("R8 no end at sample 41", {31'd0, xfer_irq}, 32'd0);
    chk("R5 sum unchanged mid-interval", xfer_sum[31:0], 32'hFFFFFEB0);
    put(24'sd1, 24'sd1, 1'b0);
    chk("R8 end at sample 42", {31'd0, xfer_irq}, 32'd1);
    chk("R8 ch0 sum", xfer_sum[31:0], 32'd42);
    clear_irq();

    // R7: new setting is 84 samples; clear coincides with the end
    grp_sel = 2'd0;
    grp_cnt = 8'd1;
    for (int k = 0; k < 83; k++) put(24'sd2, -24'sd2, 1'b0);
    chk("R1 no end at sample 83 with code 1", {31'd0, xfer_irq}, 32'd0);
    put(24'sd2, -24'sd2, 1'b1);
    chk("R7 end wins over clear", {31'd0, xfer_irq}, 32'd1);
    chk("R1 ch0 sum code 1", xfer_sum[31:0], 32'd168);
    chk("R1 ch1 sum code 1", xfer_sum[63:32], -32'sd168);
    clear_irq();
    chk("R7 plain clear", {31'd0, xfer_irq}, 32'd0);

    // R10: reset in mid-interval
    for (int k = 0; k < 5; k++) put(24'sd9, 24'sd9, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R10 sum cleared by reset", xfer_sum[31:0], 32'd0);
    for (int k = 0; k < 42; k++) put(24'sd3, 24'sd0, 1'b0);
    chk("R10 R6 fresh interval after reset", xfer_sum[31:0], 32'd126);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule